// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block sits beside the data port of a NAND bridge and builds a Hamming-style check code over a 512-byte page while the page streams through. The page is split into two 256-byte halves. Each half gets its own code: 16 line-parity bits, which locate a byte, and 6 column-parity bits, which locate a bit inside a byte. The data port moves one or two bytes per cycle. A per-lane valid strobe marks which bytes are real.

Software drives the generator through a small mode register. It writes the reset mode to clear the state and performs one throw-away transfer. It then switches to calculate mode and moves the page. Last it switches to result mode and reads three 16-bit words that hold the six code bytes. After the third word the mode falls back to plain data mode without any further write.

Top module: `nand_ecc_gen`

## Requirements
- R1: Mode codes are data = 0, reset = 1, calculate = 2, result = 3. A pulse on `mode_we_i` loads `mode_i` into the mode register, which `mode_o` shows from the next cycle. Out of reset the mode is data and `ecc_word_o` reads 0x0000.
- R2: Writing the reset mode clears both segment accumulators, the byte counter and the result read index.
- R3: The first transfer after a reset-mode write is discarded, whatever mode is current at that moment.
- R4: Only calculate mode folds bytes into the code. Bytes moved in data, reset or result mode leave the code unchanged.
- R5: `bvld_i[0]` marks the low byte `data_i[7:0]` and `bvld_i[1]` marks the high byte `data_i[15:8]`. In a two-byte cycle the low byte takes the lower page offset. A pair may straddle the 255/256 boundary, and then each byte goes to its own segment.
- R6: Bytes at offsets 0-255 feed only segment 0. Bytes at offsets 256-511 feed only segment 1.
- R7: For k = 0..7, line-parity bit 2k is the XOR of the bit-parities of every byte whose in-segment offset has bit k = 0. Bit 2k+1 covers the bytes where offset bit k = 1.
- R8: For j = 0..2, column-parity bit 2j is the XOR of the data bits (all bytes of the segment) whose bit index has bit j = 0. Bit 2j+1 covers the data bits where bit index j = 1. The column byte is {CP5..CP0, 1, 1}, with CP5 in bit 7.
- R9: Bytes beyond page offset 511 are ignored until the next reset-mode write.
- R10: Reads in result mode return the code in this order: word 0 = {seg0 LP15-8, seg0 LP7-0}, word 1 = {seg1 LP7-0, seg0 column byte}, word 2 = {seg1 column byte, seg1 LP15-8}. The first item is the high byte. The current word is on `ecc_word_o` during the cycle in which `rd_i` is high.
- R11: The read of word 2 puts the mode back to data on the next cycle.
- R12: Once the three words have been read, `ecc_word_o` shows 0xFFFF, and any further result-mode read returns 0xFFFF, until the next reset-mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Load `mode_i` into the mode register |
| mode_i | input | 2 | New mode code |
| bvld_i | input | 2 | Per-lane byte valid of the current data-port transfer |
| data_i | input | 16 | Data-port bytes, low lane in bits 7:0 |
| rd_i | input | 1 | Data-port read strobe, advances the result word in result mode |
| mode_o | output | 2 | Current mode |
| ecc_word_o | output | 16 | Current result word |

## Verification
The bench streams pages in three lane patterns. One of them forces a two-byte cycle across the segment boundary, where a design that routes by the pair's base offset would put byte 256 into segment 0. A 520-byte transfer checks the 512 limit; a counter that wraps would fold bytes 512-519 back into segment 0. Throw-away transfers in calculate mode and stray bytes in data mode catch a design that fails to skip the dummy or that accumulates outside calculate mode. Each code readout checks the exact byte interleave, the fall back to data mode, and the 0xFFFF returned on a read after the third.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    MODE_DATA   = 2'd0,
    MODE_RESET  = 2'd1,
    MODE_CALC   = 2'd2,
    MODE_RESULT = 2'd3
  } ecc_mode_e;
endpackage

// File: rtl/ecc_seg_acc.sv
module ecc_seg_acc #(
  parameter int LANES = 2,
  parameter int AW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic [LANES-1:0]             en_i,
  input  logic [LANES-1:0][AW-1:0]     off_i,
  input  logic [LANES-1:0][7:0]        byte_i,
  output logic [2*AW-1:0]              lp_o,
  output logic [7:0]                   col_o
);
  logic [AW-1:0]    lo_q, hi_q, lo_d, hi_d;
  logic [7:0]       col_q, col_d;
  logic [LANES-1:0] par;

  for (genvar l = 0; l < LANES; l++) begin : g_par
    assign par[l] = ^byte_i[l];
  end

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    col_d = col_q;
    for (int l = 0; l < LANES; l++) begin
      if (en_i[l]) begin
        col_d = col_d ^ byte_i[l];
        for (int k = 0; k < AW; k++) begin
          if (off_i[l][k]) hi_d[k] = hi_d[k] ^ par[l];
          else             lo_d[k] = lo_d[k] ^ par[l];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      lo_q  <= '0;
      hi_q  <= '0;
      col_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      col_q <= col_d;
    end
  end

  for (genvar k = 0; k < AW; k++) begin : g_lp
    assign lp_o[2*k]   = lo_q[k];
    assign lp_o[2*k+1] = hi_q[k];
  end
  assign col_o = col_q;

  // R2
  seg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lp_o == '0) && (col_o == '0));
  // R4
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i == '0) |=> $stable(lp_o) && $stable(col_o));
endmodule

// File: rtl/ecc_col_fold.sv
module ecc_col_fold (
  input  logic [7:0] col_i,
  output logic [7:0] code_o
);
  logic [5:0] cp;

  always_comb begin
    cp = '0;
    for (int j = 0; j < 3; j++) begin
      for (int i = 0; i < 8; i++) begin
        if (((i >> j) & 1) != 0) cp[2*j+1] = cp[2*j+1] ^ col_i[i];
        else                     cp[2*j]   = cp[2*j]   ^ col_i[i];
      end
    end
  end

  assign code_o = {cp, 2'b11};
endmodule

// File: rtl/ecc_result_seq.sv
module ecc_result_seq #(
  parameter int LPW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           adv_i,
  input  logic [LPW-1:0] s0_lp_i,
  input  logic [LPW-1:0] s1_lp_i,
  input  logic [7:0]     s0_col_i,
  input  logic [7:0]     s1_col_i,
  output logic [15:0]    word_o,
  output logic           last_o
);
  localparam int HB = LPW / 2;

  logic [1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      idx_q <= '0;
    else if (clr_i)                   idx_q <= '0;
    else if (adv_i && idx_q != 2'd3)  idx_q <= idx_q + 2'd1;
  end

  always_comb begin
    unique case (idx_q)
      2'd0:    word_o = {s0_lp_i[LPW-1:HB], s0_lp_i[HB-1:0]};
      2'd1:    word_o = {s1_lp_i[HB-1:0], s0_col_i};
      2'd2:    word_o = {s1_col_i, s1_lp_i[LPW-1:HB]};
      default: word_o = 16'hFFFF;
    endcase
  end

  assign last_o = adv_i && (idx_q == 2'd2);

  // R10
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && idx_q != 2'd3) |=> idx_q == $past(idx_q) + 2'd1);
  // R12
  idx_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == 2'd3 && !clr_i) |=> word_o == 16'hFFFF);
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int SEG_BYTES = 256,
  parameter int LANES     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_we_i,
  input  logic [1:0]         mode_i,
  input  logic [LANES-1:0]   bvld_i,
  input  logic [8*LANES-1:0] data_i,
  input  logic               rd_i,
  output logic [1:0]         mode_o,
  output logic [15:0]        ecc_word_o
);
  localparam int SEGS       = 2;
  localparam int PAGE_BYTES = SEG_BYTES * SEGS;
  localparam int AW         = $clog2(SEG_BYTES);
  localparam int CW         = $clog2(PAGE_BYTES + LANES);
  localparam int SW         = CW - AW;

  ecc_mode_e mode_q;
  logic [CW-1:0] cnt_q;
  logic          dummy_q;
  logic          clr, xfer, acc_en, adv, last;

  logic [LANES-1:0][CW-1:0] lane_addr;
  logic [LANES-1:0][AW-1:0] lane_off;
  logic [LANES-1:0][7:0]    lane_byte;
  logic [LANES-1:0]         take;

  logic [SEGS-1:0][LANES-1:0] seg_en;
  logic [SEGS-1:0][2*AW-1:0]  seg_lp;
  logic [SEGS-1:0][7:0]       seg_col;
  logic [SEGS-1:0][7:0]       seg_code;

  assign clr    = mode_we_i && (mode_i == MODE_RESET);
  assign xfer   = |bvld_i;
  assign acc_en = (mode_q == MODE_CALC) && !dummy_q;
  assign adv    = rd_i && (mode_q == MODE_RESULT);

  // lanes take consecutive offsets, lowest valid lane first
  always_comb begin
    logic [CW-1:0] run;
    run = cnt_q;
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = run;
      run = run + CW'(bvld_i[l]);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_byte[l] = data_i[8*l +: 8];
    assign lane_off[l]  = lane_addr[l][AW-1:0];
    assign take[l]      = acc_en && bvld_i[l] && (lane_addr[l] < CW'(PAGE_BYTES));
  end

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    for (genvar l = 0; l < LANES; l++) begin : g_sel
      assign seg_en[s][l] = take[l] && (lane_addr[l][CW-1:AW] == SW'(s));
    end

    ecc_seg_acc #(.LANES(LANES), .AW(AW)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (seg_en[s]),
      .off_i  (lane_off),
      .byte_i (lane_byte),
      .lp_o   (seg_lp[s]),
      .col_o  (seg_col[s])
    );

    ecc_col_fold u_fold (
      .col_i  (seg_col[s]),
      .code_o (seg_code[s])
    );
  end

  ecc_result_seq #(.LPW(2*AW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .adv_i    (adv),
    .s0_lp_i  (seg_lp[0]),
    .s1_lp_i  (seg_lp[1]),
    .s0_col_i (seg_code[0]),
    .s1_col_i (seg_code[1]),
    .word_o   (ecc_word_o),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_DATA;
      cnt_q   <= '0;
      dummy_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= ecc_mode_e'(mode_i);
      else if (last) mode_q <= MODE_DATA;

      if (clr)         dummy_q <= 1'b1;
      else if (xfer)   dummy_q <= 1'b0;

      if (clr)         cnt_q <= '0;
      else if (acc_en) cnt_q <= cnt_q + CW'($countones(take));
    end
  end

  assign mode_o = mode_q;

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PAGE_BYTES));
  // R2
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt_q == '0);
  // R3
  dummy_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dummy_q && xfer && !clr) |=> $stable(cnt_q) && !dummy_q);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_CALC && !clr) |=> $stable(cnt_q));
  // R11
  mode_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !mode_we_i) |=> mode_o == MODE_DATA);
  // R6
  seg_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({seg_en[0][0], seg_en[1][0]}) && $onehot0({seg_en[0][1], seg_en[1][1]}));
endmodule

// File: tb/sim_nand_ecc_gen.sv
module sim_nand_ecc_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE       = 512;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [1:0]  bvld_i = 2'b00;
  logic [15:0] data_i = 16'h0;
  logic        rd_i = 1'b0;
  logic [1:0]  mode_o;
  logic [15:0] ecc_word_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]  pg [0:519];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .bvld_i(bvld_i), .data_i(data_i), .rd_i(rd_i),
    .mode_o(mode_o), .ecc_word_o(ecc_word_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected read", ecc_word_o, 16'hxxxx);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ecc_word_o === e, t, ecc_word_o, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_we_i = 1'b1; mode_i = m;
    step();
    mode_we_i = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] v, input logic [7:0] lo, input logic [7:0] hi);
    bvld_i = v; data_i = {hi, lo};
    step();
    bvld_i = 2'b00;
  endtask

  // pat 0: pairs, 1: single bytes, 2: one single then pairs (crosses 255/256 in a pair)
  task automatic feed(input int len, input int pat);
    int i = 0;
    while (i < len) begin
      if (pat == 1 || (pat == 2 && i == 0) || i == len - 1) begin
        xfer(2'b01, pg[i], 8'h00); i += 1;
      end else begin
        xfer(2'b11, pg[i], pg[i+1]); i += 2;
      end
    end
  endtask

  task automatic model(input int len, output logic [15:0] w0, output logic [15:0] w1, output logic [15:0] w2);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [7:0]  cb [2];
    int n = (len > PAGE) ? PAGE : len;
    for (int s = 0; s < 2; s++) begin lp[s] = '0; cp[s] = '0; end
    for (int a = 0; a < n; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (pg[a][b]) begin
          int s = a / 256;
          int off = a % 256;
          for (int k = 0; k < 8; k++)
            if (((off >> k) & 1) != 0) lp[s][2*k+1] ^= 1'b1; else lp[s][2*k] ^= 1'b1;
          for (int j = 0; j < 3; j++)
            if (((b >> j) & 1) != 0) cp[s][2*j+1] ^= 1'b1; else cp[s][2*j] ^= 1'b1;
        end
      end
    end
    for (int s = 0; s < 2; s++) cb[s] = {cp[s], 2'b11};
    w0 = lp[0];
    w1 = {lp[1][7:0], cb[0]};
    w2 = {cb[1], lp[1][15:8]};
  endtask

  task automatic read_code(input int len, input string tag);
    logic [15:0] w0, w1, w2;
    model(len, w0, w1, w2);
    set_mode(2'd3);
    exp_q.push_back(w0); tag_q.push_back({"R7/R10 word0 ", tag});
    exp_q.push_back(w1); tag_q.push_back({"R8/R10 word1 ", tag});
    exp_q.push_back(w2); tag_q.push_back({"R6/R10 word2 ", tag});
    for (int r = 0; r < 3; r++) begin rd_i = 1'b1; step(); rd_i = 1'b0; end
    #2;
    chk(mode_o == 2'd0, {"R11 mode back to data ", tag}, {14'd0, mode_o}, 16'd0);
    set_mode(2'd3);
    exp_q.push_back(16'hFFFF); tag_q.push_back({"R12 fourth read ", tag});
    rd_i = 1'b1; step(); rd_i = 1'b0;
    set_mode(2'd0);
  endtask

  // variant 0: dummy in reset mode; 1: dummy in calc mode; 2: stray bytes in data mode
  task automatic run_page(input int len, input int pat, input int variant, input string tag);
    set_mode(2'd1);
    if (variant == 1) begin
      set_mode(2'd2);
      xfer(2'b11, 8'hFF, 8'h5A);
    end else begin
      xfer(2'b01, 8'hA5, 8'h00);
      if (variant == 2) begin
        set_mode(2'd0);
        xfer(2'b11, 8'h37, 8'hC1);
        xfer(2'b01, 8'h80, 8'h00);
      end
      set_mode(2'd2);
    end
    feed(len, pat);
    read_code(len, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #2;
    // R1 reset state
    chk(mode_o == 2'd0, "R1 reset mode", {14'd0, mode_o}, 16'd0);
    chk(ecc_word_o == 16'h0000, "R1 reset word", ecc_word_o, 16'h0000);
    set_mode(2'd2); #2;
    chk(mode_o == 2'd2, "R1 mode load", {14'd0, mode_o}, 16'd2);
    set_mode(2'd0);

    for (int a = 0; a < 520; a++) pg[a] = 8'h00;
    run_page(PAGE, 0, 0, "zero page");
    pg[300] = 8'h40;
    run_page(PAGE, 0, 0, "single bit seg1");
    pg[300] = 8'h00; pg[5] = 8'h81;
    run_page(PAGE, 1, 0, "single byte seg0");

    for (int a = 0; a < 520; a++) pg[a] = 8'($urandom);
    run_page(PAGE, 0, 0, "R5 random pairs");
    run_page(PAGE, 1, 0, "R5 random singles");
    run_page(PAGE, 2, 0, "R5 R6 pair straddles boundary");
    run_page(520, 0, 0, "R9 overflow bytes");
    run_page(PAGE, 2, 1, "R3 dummy in calc");
    run_page(PAGE, 0, 2, "R4 data-mode bytes");
    // R2: reclear after a full page, read code of empty page
    set_mode(2'd1);
    xfer(2'b01, 8'h11, 8'h00);
    for (int a = 0; a < 520; a++) pg[a] = 8'h00;
    #2;
    chk(ecc_word_o == 16'h0000, "R2 cleared word0", ecc_word_o, 16'h0000);
    read_code(0, "R2 cleared");

    repeat (2) step();
    if (exp_q.size() != 0) chk(1'b0, "R10 unread expectations", 16'(exp_q.size()), 16'd0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule